// File: doc/BRIEF.md
# Two-Wire Parity-Checked Serial Port

This block is the slave side of a two-wire link to a host controller. One host-driven line serves as both the bit clock and the direction select. The other line carries data both ways. While the clock line is high the host drives the data line, and the block takes in one bit per pulse. While the clock line is low, and a frame is in progress, the block drives one bit of its key-status frame back to the host. Each frame is 58 bits long in both directions. The inbound frame carries segment data for two display grids, a 10-bit dimming level and a doubled parity bit. The outbound frame carries 24 bits of key status, its own doubled parity bit, and padding of ones.

An inbound frame updates the display and dimming registers only when all 58 bits have arrived with valid parity. Any other frame leaves those registers untouched. A gap in the clock pulses aborts a partial frame, so the next pulse starts a new frame at bit 1. A supervisor switches the display into a fallback pattern if no good frame has been received for a set number of ticks. This covers silence on the link, a stream of bad frames, and the period after reset. The next good frame releases the fallback. All timing is counted in ticks of a slow bit-time strobe.

Top module: `sps_port`

## Requirements
- R1: The block asserts `sdat_oe` only while the synchronized clock line is low and a frame is active. A frame becomes active at its first pulse and stays active until the gap timeout. During the high level of every pulse `sdat_oe` is 0.
- R2: Bits are transferred bit 1 first, and each bit is sampled at the rising edge of the clock line. In an inbound frame, bits 1–23 go to grid-1 segments (bit 1 = `seg_g1_o[0]`), bits 24–46 go to grid-2 segments, bits 47–56 are the dimming level with its LSB at bit 47, and bits 57 and 58 are the two parity bits.
- R3: Let p be 1 when the 56 data bits hold an even number of ones, and 0 otherwise. A frame is good only when bit 57 and bit 58 both equal p. If the two parity bits differ, the frame is bad.
- R4: A bad frame leaves `seg_g1_o`, `seg_g2_o` and `dim_o` unchanged.
- R5: If GAP_TICKS ticks pass without a pulse, any partial frame is dropped and `sdat_oe` returns to 0. The next pulse is then taken as bit 1.
- R6: The outbound frame is bits 1–24 = `key_status_i[0..23]`, then bits 25 and 26 both equal the even-ones parity of those 24 bits, then bits 27–58 all 1. The frame is captured at the first pulse of a frame, so later changes to `key_status_i` during that frame do not affect it.
- R7: After FALLBACK_TICKS ticks without a good frame, `fallback_o` is set. While it is set, `seg_g1_o` and `seg_g2_o` both read 0x3 (only the first two segments on), and `dim_o` keeps its last value.
- R8: A good frame clears `fallback_o` and loads all three display registers.
- R9: After reset, both segment outputs are 0, `dim_o` is 0x3FF (the maximum level), `fallback_o` is 0 and `sdat_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle bit-time strobe that paces the timeouts |
| ser_en_i | input | 1 | Host clock / direction line (asynchronous) |
| sdat_i | input | 1 | Data line as seen at the pad (asynchronous) |
| key_status_i | input | 24 | Key status: [7:0] rotary, [23:8] switches |
| sdat_o | output | 1 | Outbound data bit |
| sdat_oe | output | 1 | Output enable for the data pad |
| seg_g1_o | output | 23 | Grid-1 segment pattern |
| seg_g2_o | output | 23 | Grid-2 segment pattern |
| dim_o | output | 10 | Dimming level |
| fallback_o | output | 1 | Fallback display mode active |

## Verification
The assertions check the following on every cycle:
- the data line is never driven during a sustained high level of the clock line;
- a rejected frame never disturbs the display registers;
- the bit counter stays inside the frame;
- a good frame always clears the fallback state, and fallback only starts in a cycle without a good frame.

Some behaviour can only be shown by the bench's scenarios, because it depends on whole sequences:
- the bit-to-field mapping and the parity rule;
- the contents of the outbound frame and its capture at the first pulse;
- realignment after a gap;
- the fallback reached by silence, by persistent errors and after reset.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int SEG_W   = 23;
  localparam int DIM_W   = 10;
  localparam int DATA_W  = 2 * SEG_W + DIM_W;
  localparam int FRAME_W = DATA_W + 2;
  localparam int KEY_W   = 24;
  localparam int PAD_W   = FRAME_W - KEY_W - 2;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic [DIM_W-1:0] dim;
    logic [SEG_W-1:0] g2;
    logic [SEG_W-1:0] g1;
  } disp_t;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;
  logic [CW-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CW-W-1:0], d};
  end

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/sps_rx.sv
module sps_rx
  import sps_pkg::*;
#(
  parameter int GAP_TICKS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rise,
  input  logic             din,
  output logic             active,
  output logic             frame_start,
  output logic             ok_p,
  output logic             bad_p,
  output disp_t            disp,
  output logic [CNT_W-1:0] cnt
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_W - 1);
  localparam logic [GW-1:0]    GAP_END = GW'(GAP_TICKS - 1);

  logic [FRAME_W-1:0] sr, nxt;
  logic [GW-1:0]      gap;
  logic               par_ok;

  assign nxt         = {din, sr[FRAME_W-1:1]};
  assign par_ok      = (nxt[FRAME_W-2] == nxt[FRAME_W-1]) &&
                       (nxt[FRAME_W-2] == ~^nxt[DATA_W-1:0]);
  assign frame_start = rise && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      cnt    <= '0;
      gap    <= '0;
      active <= 1'b0;
      ok_p   <= 1'b0;
      bad_p  <= 1'b0;
      disp   <= '{dim: '1, g2: '0, g1: '0};
    end else begin
      ok_p  <= 1'b0;
      bad_p <= 1'b0;
      if (rise) begin
        active <= 1'b1;
        gap    <= '0;
        sr     <= nxt;
        if (cnt == LAST) begin
          cnt <= '0;
          if (par_ok) begin
            ok_p <= 1'b1;
            disp <= disp_t'(nxt[DATA_W-1:0]);
          end else begin
            bad_p <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (active && tick) begin
        if (gap == GAP_END) begin
          active <= 1'b0;
          cnt    <= '0;
          gap    <= '0;
        end else begin
          gap <= gap + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sps_tx.sv
module sps_tx
  import sps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [KEY_W-1:0] key,
  output logic             dout
);
  logic [FRAME_W-1:0] sr;
  logic               kpar;

  assign kpar = ~^key;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '1;
    else if (load)  sr <= {{PAD_W{1'b1}}, kpar, kpar, key};
    else if (shift) sr <= {1'b1, sr[FRAME_W-1:1]};
  end

  assign dout = sr[0];
endmodule

// File: rtl/sps_sup.sv
module sps_sup #(
  parameter int FALLBACK_TICKS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic good,
  output logic fb
);
  localparam int AW = $clog2(FALLBACK_TICKS + 1);
  localparam logic [AW-1:0] AGE_END = AW'(FALLBACK_TICKS - 1);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
      fb  <= 1'b0;
    end else if (good) begin
      age <= '0;
      fb  <= 1'b0;
    end else if (tick && !fb) begin
      if (age == AGE_END) fb  <= 1'b1;
      else                age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/sps_port.sv
module sps_port
  import sps_pkg::*;
#(
  parameter int GAP_TICKS      = 5,
  parameter int FALLBACK_TICKS = 512,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ser_en_i,
  input  logic             sdat_i,
  input  logic [KEY_W-1:0] key_status_i,
  output logic             sdat_o,
  output logic             sdat_oe,
  output logic [SEG_W-1:0] seg_g1_o,
  output logic [SEG_W-1:0] seg_g2_o,
  output logic [DIM_W-1:0] dim_o,
  output logic             fallback_o
);
  localparam logic [SEG_W-1:0] FB_SEGS = SEG_W'(3);

  logic             en_s, din_s, en_d, rise;
  logic             active, frame_start, rx_ok, rx_bad, tx_dout, fb;
  logic [CNT_W-1:0] rx_cnt;
  disp_t            disp;

  sps_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ser_en_i, sdat_i}), .q({en_s, din_s})
  );

  always_ff @(posedge clk) begin
    if (rst) en_d <= 1'b0;
    else     en_d <= en_s;
  end
  assign rise = en_s && !en_d;

  sps_rx #(.GAP_TICKS(GAP_TICKS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick_i), .rise(rise), .din(din_s),
    .active(active), .frame_start(frame_start), .ok_p(rx_ok),
    .bad_p(rx_bad), .disp(disp), .cnt(rx_cnt)
  );

  sps_tx u_tx (
    .clk(clk), .rst(rst), .load(frame_start), .shift(rise && !frame_start),
    .key(key_status_i), .dout(tx_dout)
  );

  sps_sup #(.FALLBACK_TICKS(FALLBACK_TICKS)) u_sup (
    .clk(clk), .rst(rst), .tick(tick_i), .good(rx_ok), .fb(fb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_g1_o   <= '0;
      seg_g2_o   <= '0;
      dim_o      <= '1;
      fallback_o <= 1'b0;
      sdat_o     <= 1'b1;
      sdat_oe    <= 1'b0;
    end else begin
      seg_g1_o   <= fb ? FB_SEGS : disp.g1;
      seg_g2_o   <= fb ? FB_SEGS : disp.g2;
      dim_o      <= disp.dim;
      fallback_o <= fb;
      sdat_o     <= tx_dout;
      sdat_oe    <= !en_s && active;
    end
  end
endmodule

// File: rtl/sps_port_chk.sv
module sps_port_chk
  import sps_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             en_s,
  input logic             sdat_oe,
  input logic             rx_ok,
  input logic             rx_bad,
  input disp_t            disp,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             fb
);
  assert_hiz_high_R1: assert property (@(posedge clk) disable iff (rst)
    (en_s && $past(en_s)) |-> !sdat_oe);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CNT_W'(FRAME_W - 1));

  assert_bad_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    rx_bad |-> $stable(disp));

  assert_ok_bad_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(rx_ok && rx_bad));

  assert_fb_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fb) |-> !$past(rx_ok));

  assert_ok_clears_R8: assert property (@(posedge clk) disable iff (rst)
    rx_ok |=> !fb);
endmodule

bind sps_port sps_port_chk u_chk (
  .clk(clk), .rst(rst), .en_s(en_s), .sdat_oe(sdat_oe), .rx_ok(rx_ok),
  .rx_bad(rx_bad), .disp(disp), .rx_cnt(rx_cnt), .fb(fb)
);

// File: tb/sps_port_bench.sv
module sps_port_bench;
  import sps_pkg::*;

  localparam int GAP_T = 4;
  localparam int FB_T  = 300;

  logic             clk = 1'b0, rst = 1'b1, tick = 1'b0, en = 1'b0, din = 1'b0;
  logic [KEY_W-1:0] key = '0;
  logic             sdat_o, sdat_oe, fallback_o;
  logic [SEG_W-1:0] seg_g1_o, seg_g2_o;
  logic [DIM_W-1:0] dim_o;
  int               tc = 0;
  int               errors = 0, checks = 0;
  logic [SEG_W-1:0] e_g1 = '0, e_g2 = '0;
  logic [DIM_W-1:0] e_dim = '1;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tc   <= (tc == 7) ? 0 : tc + 1;
    tick <= (tc == 7);
  end

  sps_port #(.GAP_TICKS(GAP_T), .FALLBACK_TICKS(FB_T)) u_sps_port (
    .clk(clk), .rst(rst), .tick_i(tick), .ser_en_i(en), .sdat_i(din),
    .key_status_i(key), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
    .seg_g1_o(seg_g1_o), .seg_g2_o(seg_g2_o), .dim_o(dim_o),
    .fallback_o(fallback_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [SEG_W-1:0] g1,
      input logic [SEG_W-1:0] g2, input logic [DIM_W-1:0] dim);
    logic [DATA_W-1:0] d;
    logic p;
    d = {dim, g2, g1};
    p = ~^d;
    return {p, p, d};
  endfunction

  function automatic logic [FRAME_W-1:0] key_frame(input logic [KEY_W-1:0] k);
    logic p;
    p = ~^k;
    return {{PAD_W{1'b1}}, p, p, k};
  endfunction

  task automatic send(input logic [FRAME_W-1:0] f, input int n,
      output logic [FRAME_W-1:0] got, output int oe_err);
    got = '1;
    oe_err = 0;
    for (int k = 0; k < n; k++) begin
      din = f[k];
      step(2);
      en = 1'b1;
      step(5);
      if (sdat_oe !== 1'b0) oe_err++;
      if (k == 0) key = $urandom;
      step(3);
      en = 1'b0;
      step(5);
      if (sdat_oe !== 1'b1) oe_err++;
      got[k] = sdat_o;
      step(3);
    end
    step(4);
  endtask

  task automatic check_disp(input string req);
    check({req, " seg_g1"}, 64'(seg_g1_o), 64'(e_g1));
    check({req, " seg_g2"}, 64'(seg_g2_o), 64'(e_g2));
    check({req, " dim"},    64'(dim_o),    64'(e_dim));
  endtask

  // full frame; good=1 updates the model (R2, R3, R8); tx side R6, R1
  task automatic frame(input logic [FRAME_W-1:0] f, input bit good, input string req);
    logic [KEY_W-1:0]   kprev;
    logic [FRAME_W-1:0] got;
    int                 oe_err;
    kprev = key;
    send(f, FRAME_W, got, oe_err);
    check("R6 outbound frame", 64'(got), 64'(key_frame(kprev)));
    check("R1 drive direction", 64'(oe_err), 64'd0);
    if (good) begin
      e_g1  = f[SEG_W-1:0];
      e_g2  = f[2*SEG_W-1:SEG_W];
      e_dim = f[DATA_W-1:2*SEG_W];
      check("R8 fallback cleared", 64'(fallback_o), 64'd0);
    end
    check_disp(req);
  endtask

  task automatic rnd_good(input string req);
    frame(mk_frame(SEG_W'($urandom), SEG_W'($urandom), DIM_W'($urandom)), 1'b1, req);
  endtask

  task automatic check_fallback(input string req);
    check({req, " flag"}, 64'(fallback_o), 64'd1);
    check({req, " seg_g1"}, 64'(seg_g1_o), 64'h3);
    check({req, " seg_g2"}, 64'(seg_g2_o), 64'h3);
    check({req, " dim kept"}, 64'(dim_o), 64'(e_dim));
  endtask

  initial begin
    logic [FRAME_W-1:0] f, got;
    int                 oe_err;
    void'($urandom(32'h5EED_1234));
    key = $urandom;
    step(3);
    rst = 1'b0;
    step(3);
    // R9 reset state
    check("R9 seg_g1", 64'(seg_g1_o), 64'd0);
    check("R9 seg_g2", 64'(seg_g2_o), 64'd0);
    check("R9 dim", 64'(dim_o), 64'h3FF);
    check("R9 fallback", 64'(fallback_o), 64'd0);
    check("R9 oe", 64'(sdat_oe), 64'd0);
    // R7 fallback after reset with maximum dimming
    step(FB_T * 8 + 40);
    check_fallback("R7 power-on");
    // R2 R3 R8 random good frames
    for (int i = 0; i < 5; i++) rnd_good("R2 good frame");
    // R3 corner: all-zero and all-one data
    frame(mk_frame('0, '0, '0), 1'b1, "R3 zero data");
    frame(mk_frame('1, '1, '1), 1'b1, "R3 all-one data");
    rnd_good("R2 good frame");
    // R4 both parity bits inverted
    f = mk_frame(SEG_W'($urandom), SEG_W'($urandom), DIM_W'($urandom));
    f[FRAME_W-1] = ~f[FRAME_W-1];
    f[FRAME_W-2] = ~f[FRAME_W-2];
    frame(f, 1'b0, "R4 bad parity kept");
    rnd_good("R2 good frame");
    // R3 parity bits disagree
    f = mk_frame(SEG_W'($urandom), SEG_W'($urandom), DIM_W'($urandom));
    f[FRAME_W-1] = ~f[FRAME_W-1];
    frame(f, 1'b0, "R3 parity mismatch kept");
    rnd_good("R2 good frame");
    // R5 partial frame, gap, then realigned frame
    f = mk_frame(SEG_W'($urandom), SEG_W'($urandom), DIM_W'($urandom));
    send(f, 20, got, oe_err);
    step((GAP_T + 3) * 8);
    check("R5 oe after gap", 64'(sdat_oe), 64'd0);
    check_disp("R5 partial ignored");
    rnd_good("R5 realigned frame");
    // R7 silence
    step(FB_T * 8 + 40);
    check_fallback("R7 silence");
    rnd_good("R8 recovery");
    // R7 persistent parity errors
    for (int i = 0; i < 3; i++) begin
      f = mk_frame(SEG_W'($urandom), SEG_W'($urandom), DIM_W'($urandom));
      f[FRAME_W-2] = ~f[FRAME_W-2];
      f[FRAME_W-1] = ~f[FRAME_W-1];
      send(f, FRAME_W, got, oe_err);
    end
    check_fallback("R7 persistent errors");
    rnd_good("R8 recovery");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule